// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block is a serial-bus master for a two-channel sampling converter. A single start request opens one transaction. The block raises a convert strobe for one serial-clock period and then runs a fixed burst of 34 serial clocks. The serial clock comes from the system clock through a parameterised divider. During the burst the block shifts in two 14-bit two's-complement results, channel 0 first and channel 1 second, each sent most significant bit first. It skips the turnaround slots around each field, when the converter's output is high-impedance.

When the burst ends, the block sign-extends both results to the output width and presents them together with a one-cycle valid pulse. The converter returns the conversion that the previous convert strobe started. For that reason the first transaction after reset updates the words but gives no valid pulse. While a transaction is running the block reports busy, and it ignores any further start request.

Top module: `adc_pair_capture`

## Requirements
- R1: After reset, the convert strobe, serial clock, busy and valid are low and both sample words are zero.
- R2: A start request seen at a clock edge while idle drives the convert strobe high from that edge for exactly 2*SCLK_HALF system clocks. The serial clock stays low while the strobe is high.
- R3: After the strobe, the serial clock runs exactly 34 cycles. Each cycle is SCLK_HALF system clocks low followed by SCLK_HALF high. The serial clock idles low outside a transaction.
- R4: Busy rises on the accepting edge and stays high for 35*2*SCLK_HALF system clocks: the strobe period plus 34 serial periods.
- R5: The data line is sampled at each rising serial-clock edge. Serial cycles 3 to 16, counting from 1, carry channel 0 bits 13 down to 0.
- R6: Serial cycles 19 to 32 carry channel 1 bits 13 down to 0.
- R7: The data line in serial cycles 1, 2, 17, 18, 33 and 34 has no effect on either word.
- R8: Each 14-bit result appears on its 16-bit word sign-extended: bits 15 and 14 copy bit 13.
- R9: Both words update, and valid pulses for exactly one system clock, on the edge where busy falls. The first transaction after a reset updates the words without a valid pulse.
- R10: A start request while busy is ignored, including one at the final edge of a transaction. A request in the cycle where valid is high starts a new transaction at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run one transaction |
| miso_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe |
| sclk_o | output | 1 | Serial clock, idles low |
| ch0_word_o | output | 16 | Channel 0 result, sign-extended |
| ch1_word_o | output | 16 | Channel 1 result, sign-extended |
| valid_o | output | 1 | One-cycle pulse, both words fresh and valid |
| busy_o | output | 1 | Transaction in progress |

## Verification
The end of one transaction and the start of the next can fall in the same cycle, and the bench provokes this in two ways. In one, start is raised so that it is sampled on the very edge that drops busy; the sequencer still sees busy there, so the bench expects the request to be dropped and no strobe to follow. In the other, start is raised while valid is high, and the bench expects a strobe from the very next edge, with back-to-back transactions and correct words in both. Each case is judged cycle by cycle against strobe, busy, serial-clock and valid levels computed from the divider setting. Every transaction also carries a stray start request in its middle and drives ones in all turnaround slots.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

   // First serial cycle (counted from 1) that carries field `ch`
   function automatic int unsigned field_first_cyc(int unsigned ch, int unsigned gap,
                                                   int unsigned width);
      return gap * (ch + 1) + width * ch + 1;
   endfunction

   // Serial cycles in one transaction: a gap around every field
   function automatic int unsigned frame_cycles(int unsigned nch, int unsigned gap,
                                                int unsigned width);
      return gap * (nch + 1) + width * nch;
   endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
   parameter int unsigned HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic sclk_en_i,
   output logic wrap_o,
   output logic rise_o,
   output logic sclk_o
);
   localparam int unsigned PERIOD = 2 * HALF;
   localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(PERIOD - 1);
   localparam logic [CNT_W-1:0] DIV_RISE = CNT_W'(HALF - 1);

   logic [CNT_W-1:0] div_q;
   logic             sclk_q;

   initial begin
      assert (HALF >= 1) else $error("adc_sclk_div: HALF must be at least 1");
   end

   assign wrap_o = run_i && (div_q == DIV_LAST);
   assign rise_o = run_i && (div_q == DIV_RISE);
   assign sclk_o = sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         sclk_q <= 1'b0;
      end else begin
         if (!run_i || wrap_o) div_q <= '0;
         else                  div_q <= div_q + 1'b1;

         if (!run_i || wrap_o)         sclk_q <= 1'b0;
         else if (rise_o && sclk_en_i) sclk_q <= 1'b1;
      end
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> !sclk_q); // R3

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
   parameter int unsigned FRAME = 34,
   parameter int unsigned CYC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             wrap_i,
   output logic             busy_o,
   output logic             conv_o,
   output logic             valid_o,
   output logic             last_o,
   output logic [CYC_W-1:0] cyc_o
);
   logic             busy_q, conv_q, primed_q, valid_q;
   logic [CYC_W-1:0] cyc_q;
   logic             accept;

   initial begin
      assert (FRAME >= 1 && FRAME < (1 << CYC_W))
         else $error("adc_frame_seq: CYC_W too narrow for FRAME");
   end

   assign accept = start_i && !busy_q;
   assign last_o = busy_q && wrap_i && (cyc_q == CYC_W'(FRAME));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         conv_q   <= 1'b0;
         primed_q <= 1'b0;
         valid_q  <= 1'b0;
         cyc_q    <= '0;
      end else begin
         valid_q <= last_o && primed_q;
         if (accept) begin
            busy_q <= 1'b1;
            conv_q <= 1'b1;
            cyc_q  <= '0;
         end else if (busy_q && wrap_i) begin
            cyc_q <= cyc_q + 1'b1;
            if (cyc_q == '0) conv_q <= 1'b0;
            if (last_o) begin
               busy_q   <= 1'b0;
               primed_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign conv_o  = conv_q;
   assign valid_o = valid_q;
   assign cyc_o   = cyc_q;

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R9
   AST_VALID_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> !busy_q); // R4
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && cyc_q != '0) |=> !conv_q); // R10

endmodule

// File: rtl/adc_chan_shift.sv
module adc_chan_shift #(
   parameter int unsigned W     = 14,
   parameter int unsigned OUT_W = 16,
   parameter int unsigned FIRST = 3,
   parameter int unsigned CYC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_i,
   input  logic [CYC_W-1:0] cyc_i,
   input  logic             miso_i,
   input  logic             load_i,
   output logic [OUT_W-1:0] word_o
);
   localparam logic [CYC_W-1:0] WIN_LO = CYC_W'(FIRST);
   localparam logic [CYC_W-1:0] WIN_HI = CYC_W'(FIRST + W - 1);

   logic [W-1:0]     sh_q;
   logic [OUT_W-1:0] word_q;
   logic [OUT_W-1:0] ext;
   logic             in_win;

   initial begin
      assert (OUT_W >= W) else $error("adc_chan_shift: OUT_W narrower than W");
      assert (W >= 2) else $error("adc_chan_shift: W must be at least 2");
   end

   assign in_win = (cyc_i >= WIN_LO) && (cyc_i <= WIN_HI);

   generate
      if (OUT_W > W) begin : g_extend
         assign ext = {{(OUT_W - W){sh_q[W-1]}}, sh_q};
      end else begin : g_plain
         assign ext = sh_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         word_q <= '0;
      end else begin
         if (sample_i && in_win) sh_q <= {sh_q[W-2:0], miso_i};
         if (load_i) word_q <= ext;
      end
   end

   assign word_o = word_q;

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_i) |-> $stable(word_q)); // R9

endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture #(
   parameter int unsigned SCLK_HALF = 2,
   parameter int unsigned SAMPLE_W  = 14,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned GAP_CLKS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              miso_i,
   output logic              conv_o,
   output logic              sclk_o,
   output logic [WORD_W-1:0] ch0_word_o,
   output logic [WORD_W-1:0] ch1_word_o,
   output logic              valid_o,
   output logic              busy_o
);
   import adc_cap_pkg::*;

   localparam int unsigned NCH   = 2;
   localparam int unsigned FRAME = frame_cycles(NCH, GAP_CLKS, SAMPLE_W);
   localparam int unsigned CYC_W = $clog2(FRAME + 1);

   logic             wrap, rise, last, busy;
   logic [CYC_W-1:0] cyc;
   logic [WORD_W-1:0] words [NCH];

   initial begin
      assert (FRAME == 34) else $error("adc_pair_capture: transaction must be 34 cycles");
   end

   adc_frame_seq #(.FRAME(FRAME), .CYC_W(CYC_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .wrap_i (wrap),
      .busy_o (busy),
      .conv_o (conv_o),
      .valid_o(valid_o),
      .last_o (last),
      .cyc_o  (cyc)
   );

   adc_sclk_div #(.HALF(SCLK_HALF)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (busy),
      .sclk_en_i(cyc != '0),
      .wrap_o   (wrap),
      .rise_o   (rise),
      .sclk_o   (sclk_o)
   );

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         adc_chan_shift #(
            .W    (SAMPLE_W),
            .OUT_W(WORD_W),
            .FIRST(field_first_cyc(ch, GAP_CLKS, SAMPLE_W)),
            .CYC_W(CYC_W)
         ) u_shift (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample_i(rise),
            .cyc_i   (cyc),
            .miso_i  (miso_i),
            .load_i  (last),
            .word_o  (words[ch])
         );
      end
   endgenerate

   assign ch0_word_o = words[0];
   assign ch1_word_o = words[1];
   assign busy_o     = busy;

   AST_CONV_NO_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      conv_o |-> !sclk_o); // R2
   AST_BUSY_FALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $fell(busy_o)); // R9

endmodule

// File: tb/adc_pair_capture_test.sv
module adc_pair_capture_test;
   localparam int HALF = 2;
   localparam int P    = 2 * HALF;
   localparam int END  = 35 * P;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        miso_i = 1'b1;
   logic        conv_o, sclk_o, valid_o, busy_o;
   logic [15:0] ch0_word_o, ch1_word_o;

   logic [13:0] tx0 = '0, tx1 = '0;
   int          tests = 0, fails = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   adc_pair_capture #(.SCLK_HALF(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .miso_i(miso_i),
      .conv_o(conv_o), .sclk_o(sclk_o), .ch0_word_o(ch0_word_o),
      .ch1_word_o(ch1_word_o), .valid_o(valid_o), .busy_o(busy_o)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Bit the converter model drives in serial cycle k (ones in every gap)
   function automatic logic fbit(int k);
      if (k >= 3 && k <= 16)  return tx0[16 - k];
      if (k >= 19 && k <= 32) return tx1[32 - k];
      return 1'b1;
   endfunction

   function automatic logic [15:0] sext(logic [13:0] v);
      return {{2{v[13]}}, v};
   endfunction

   // Converter model: data changes after each falling serial edge
   initial begin
      forever begin
         @(posedge conv_o);
         miso_i = fbit(1);
         for (int k = 1; k <= 34; k++) begin
            @(negedge sclk_o);
            miso_i = fbit(k + 1);
         end
      end
   end

   task automatic do_reset();
      rst_n   = 1'b0;
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!conv_o && !sclk_o && !busy_o && !valid_o, "R1", "idle controls",
          {conv_o, sclk_o, busy_o, valid_o}, 0);
      chk(ch0_word_o == 0 && ch1_word_o == 0, "R1", "words after reset",
          {ch0_word_o, ch1_word_o}, 0);
   endtask

   // tail: 0 plain end, 1 start lands on the final edge, 2 chain next start
   task automatic run_frame(logic [13:0] a, logic [13:0] b, bit expv, int tail);
      int bad_conv = 0, bad_busy = 0, bad_sclk = 0, bad_valid = 0;
      int rises = 0, highs = 0;
      logic prev_sclk = 1'b0;
      int last_j;
      tx0 = a;
      tx1 = b;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      last_j = (tail == 2) ? END + 1 : END + 3;
      for (int j = 1; j <= last_j; j++) begin
         int  c    = (j - 1) / P;
         int  d    = (j - 1) % P;
         bit  e_cv = (j <= P);
         bit  e_bs = (j <= END);
         bit  e_sk = (c >= 1 && c <= 34 && d >= HALF);
         bit  e_vl = (j == END + 1) && expv;
         if (conv_o !== e_cv && bad_conv == 0)  bad_conv  = j;
         if (busy_o !== e_bs && bad_busy == 0)  bad_busy  = j;
         if (sclk_o !== e_sk && bad_sclk == 0)  bad_sclk  = j;
         if (valid_o !== e_vl && bad_valid == 0) bad_valid = j;
         if (sclk_o && !prev_sclk) rises++;
         if (sclk_o) highs++;
         prev_sclk = sclk_o;
         if (j == END + 1) begin
            chk(ch0_word_o == sext(a), "R5/R7/R8", "channel 0 word",
                ch0_word_o, sext(a));
            chk(ch1_word_o == sext(b), "R6/R7/R8", "channel 1 word",
                ch1_word_o, sext(b));
         end
         // stray request in mid-transaction (R10)
         start_i = (j == 50) || (tail == 1 && j == END) || (tail == 2 && j == END + 1);
         if (j < last_j) @(negedge clk);
      end
      chk(bad_conv == 0, "R2/R10", "convert strobe first bad cycle", bad_conv, 0);
      chk(bad_busy == 0, "R4/R10", "busy first bad cycle", bad_busy, 0);
      chk(bad_sclk == 0, "R3", "serial clock first bad cycle", bad_sclk, 0);
      chk(rises == 34 && highs == 34 * HALF, "R3", "serial clock rises",
          rises, 34);
      chk(bad_valid == 0, "R9", "valid first bad cycle", bad_valid, 0);
      if (tail != 2) start_i = 1'b0;
   endtask

   initial begin
      logic [13:0] corner0 [8] = '{14'h0000, 14'h3FFF, 14'h1FFF, 14'h2000,
                                   14'h2AAA, 14'h1555, 14'h0001, 14'h3FFE};
      bit primed = 1'b0;
      do_reset();
      for (int i = 0; i < 30; i++) begin
         logic [13:0] a, b;
         int tail;
         if (i == 20) begin
            do_reset();
            primed = 1'b0;
         end
         if (i < 8) begin
            a = corner0[i];
            b = corner0[7 - i];
         end else begin
            a = 14'((i * 32'h1357) ^ (i << 9));
            b = ~a + 14'(i);
         end
         tail = (i % 5 == 2 && i != 19) ? 2 : ((i % 7 == 3) ? 1 : 0);
         run_frame(a, b, primed, tail);   // R9: no pulse on the first frame
         primed = 1'b1;
      end
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule